// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block gives the two ports of a shared memory a way to signal each other. Each port owns one mailbox word near the top of the address space. When the opposite port writes into that word, the owner's interrupt goes active. The owner acknowledges by reading its own mailbox, and that read drops the interrupt. The stored word is free-form user data, and the logic places no meaning on it.

Each side has a busy input that comes from the external arbiter. While busy is active toward a port, that port cannot deliver a message to its peer. A write from that port is not stored and does not raise the peer's flag. The same port also cannot acknowledge its own interrupt while busy is active. It still receives the mailbox contents on such a read, but the flag stays set.

The left port's mailbox sits at the all-ones address. The right port's mailbox sits one address below it. Each mailbox is written only by the opposite side. The interrupt outputs are active-low and come from flops. Read data is registered and appears one cycle after the read request. The reset input asserts asynchronously, and its release is synchronised inside the block over two clock edges.

Top module: `mbx_dualport_irq`

## Requirements
- R1: While reset is held, and after it is released, both interrupt outputs are high (inactive) and both read-data outputs are zero.
- R2: A non-busy right-port write (cs=1, we=1) to address all-ones stores the write data in the left mailbox, and l_irq_n is low from the next cycle.
- R3: A non-busy left-port write to address all-ones minus one stores the write data in the right mailbox, and r_irq_n is low from the next cycle.
- R4: A non-busy read (cs=1, we=0) by a port of its own mailbox returns the stored word on that port's rdata in the next cycle, and that port's interrupt goes high in that same cycle.
- R5: A port may read the other port's mailbox and receives its contents in the next cycle, and neither interrupt flag changes.
- R6: A write from a port whose busy input is 1 stores nothing and leaves the peer's interrupt unchanged.
- R7: A read of its own mailbox by a port whose busy input is 1 still returns the stored word, but the port's interrupt stays asserted.
- R8: If in one cycle a port reads its own mailbox and the peer writes that same mailbox, the interrupt stays asserted. The read returns the old word, and the new word is stored.
- R9: Accesses to any other address, and accesses with cs=0, change no mailbox and no flag. rdata is zero in every cycle that does not follow a mailbox read.
- R10: A write by a port to its own mailbox is ignored: the contents and both flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write (1) / read (0) |
| l_addr | input | AW | Left port address |
| l_wdata | input | DW | Left port write data |
| l_busy | input | 1 | Arbiter busy toward the left port |
| l_rdata | output | DW | Left port registered read data |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_cs | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write (1) / read (0) |
| r_addr | input | AW | Right port address |
| r_wdata | input | DW | Right port write data |
| r_busy | input | 1 | Arbiter busy toward the right port |
| r_rdata | output | DW | Right port registered read data |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The assertions check the flag rules on every cycle:
- a qualified delivery always asserts the flag;
- a lone acknowledge always releases it;
- a flag never moves without a strobe;
- busy never lets a write or an acknowledge through.

Only the bench's scenarios can show that the right word reaches the right port's read data one cycle later. They also show that a simultaneous acknowledge and delivery returns the old word and keeps the new one, and that the owner's writes to its own mailbox and accesses to unrelated addresses are silently dropped.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_OWN  = 2'd1,
    RSEL_PEER = 2'd2
  } rsel_e;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_int_n = stage_q[1];
endmodule

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] OWN_ADDR  = '1,
  parameter logic [AW-1:0] PEER_ADDR = '0
) (
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  output logic          wr_peer,
  output logic          rd_own_ack,
  output rsel_e         rsel
);
  logic hit_own, hit_peer;

  always_comb begin
    hit_own    = (addr == OWN_ADDR);
    hit_peer   = (addr == PEER_ADDR);
    wr_peer    = cs && we && hit_peer && !busy;
    rd_own_ack = cs && !we && hit_own && !busy;
    if (cs && !we && hit_own)       rsel = RSEL_OWN;
    else if (cs && !we && hit_peer) rsel = RSEL_PEER;
    else                            rsel = RSEL_NONE;
  end
endmodule

// File: rtl/mbx_box.sv
module mbx_box #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_set,
  input  logic          rd_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] data,
  output logic          irq_n
);
  logic [DW-1:0] data_q, data_d;
  logic          flag_q, flag_d;
  logic          data_en;

  always_comb begin
    data_en = wr_set;
    data_d  = wdata;
    if (wr_set)      flag_d = 1'b1;
    else if (rd_clr) flag_d = 1'b0;
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (data_en) data_q <= data_d;
      flag_q <= flag_d;
    end
  end

  assign data  = data_q;
  assign irq_n = ~flag_q;

  AST_SET_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> !irq_n); // R2
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !wr_set) |=> irq_n); // R4
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && wr_set) |=> !irq_n); // R8
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_set && !rd_clr) |=> $stable(irq_n)); // R5
  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_set |=> $stable(data)); // R10
  AST_DATA_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (data == $past(wdata))); // R3
endmodule

// File: rtl/mbx_dualport_irq.sv
module mbx_dualport_irq
  import mbx_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic          l_busy,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq_n,
  input  logic          r_cs,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  input  logic          r_busy,
  output logic [DW-1:0] r_rdata,
  output logic          r_irq_n
);
  localparam int unsigned NSIDE = 2;
  localparam logic [AW-1:0] ADDR_L = '1;
  localparam logic [AW-1:0] ADDR_R = ADDR_L - 1'b1;

  logic          rst_int_n;
  logic          cs_a    [NSIDE];
  logic          we_a    [NSIDE];
  logic [AW-1:0] addr_a  [NSIDE];
  logic [DW-1:0] wdata_a [NSIDE];
  logic          busy_a  [NSIDE];
  logic          wr_peer [NSIDE];
  logic          rd_ack  [NSIDE];
  rsel_e         rsel    [NSIDE];
  logic [DW-1:0] box_d   [NSIDE];
  logic          irqn_a  [NSIDE];
  logic [DW-1:0] rd_d    [NSIDE];
  logic [DW-1:0] rd_q    [NSIDE];

  mbx_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  always_comb begin
    cs_a[0] = l_cs;  we_a[0] = l_we;  addr_a[0] = l_addr;
    wdata_a[0] = l_wdata;  busy_a[0] = l_busy;
    cs_a[1] = r_cs;  we_a[1] = r_we;  addr_a[1] = r_addr;
    wdata_a[1] = r_wdata;  busy_a[1] = r_busy;
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    localparam int unsigned PEER = NSIDE - 1 - g;
    localparam logic [AW-1:0] OWN_A  = (g == 0) ? ADDR_L : ADDR_R;
    localparam logic [AW-1:0] PEER_A = (g == 0) ? ADDR_R : ADDR_L;

    mbx_port_dec #(
      .AW        (AW),
      .OWN_ADDR  (OWN_A),
      .PEER_ADDR (PEER_A)
    ) i_dec (
      .cs         (cs_a[g]),
      .we         (we_a[g]),
      .addr       (addr_a[g]),
      .busy       (busy_a[g]),
      .wr_peer    (wr_peer[g]),
      .rd_own_ack (rd_ack[g]),
      .rsel       (rsel[g])
    );

    mbx_box #(.DW(DW)) i_box (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .wr_set (wr_peer[PEER]),
      .rd_clr (rd_ack[g]),
      .wdata  (wdata_a[PEER]),
      .data   (box_d[g]),
      .irq_n  (irqn_a[g])
    );

    always_comb begin
      unique case (rsel[g])
        RSEL_OWN:  rd_d[g] = box_d[g];
        RSEL_PEER: rd_d[g] = box_d[PEER];
        default:   rd_d[g] = '0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) rd_q[g] <= '0;
      else            rd_q[g] <= rd_d[g];
    end
  end

  assign l_rdata = rd_q[0];
  assign r_rdata = rd_q[1];
  assign l_irq_n = irqn_a[0];
  assign r_irq_n = irqn_a[1];

  AST_L_BUSY_NO_SET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (l_cs && l_we && l_busy && r_irq_n) |=> r_irq_n); // R6
  AST_R_BUSY_NO_SET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (r_cs && r_we && r_busy && l_irq_n) |=> l_irq_n); // R6
  AST_L_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (l_cs && !l_we && l_addr == ADDR_L && l_busy && !l_irq_n) |=> !l_irq_n); // R7
  AST_R_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (r_cs && !r_we && r_addr == ADDR_R && r_busy && !r_irq_n) |=> !r_irq_n); // R7
  AST_IDLE_ZERO_RD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !l_cs |=> (l_rdata == '0)); // R9
endmodule

// File: tb/test_mbx_dualport_irq.sv
`timescale 1ns/1ps
module test_mbx_dualport_irq;
  logic clk = 1'b0;
  logic rst_n;
  logic l_cs, l_we, l_busy, r_cs, r_we, r_busy;
  logic [7:0] l_addr, r_addr;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  mbx_dualport_irq #(.AW(8), .DW(16)) i_mbx_dualport_irq (
    .clk(clk), .rst_n(rst_n),
    .l_cs(l_cs), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_busy(l_busy), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_cs(r_cs), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_busy(r_busy), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  typedef struct packed {
    logic lcs; logic lwe; logic [7:0] la; logic [15:0] lw; logic lb;
    logic rcs; logic rwe; logic [7:0] ra; logic [15:0] rw; logic rb;
    logic elirq; logic erirq; logic [15:0] elrd; logic [15:0] errd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    // R9 idle
    '{1'b0,1'b0,8'h00,16'h0000,1'b0, 1'b0,1'b0,8'h00,16'h0000,1'b0, 1'b1,1'b1,16'h0000,16'h0000,4'd9},
    // R2 right delivers to left mailbox
    '{1'b0,1'b0,8'h00,16'h0000,1'b0, 1'b1,1'b1,8'hFF,16'hA5A5,1'b0, 1'b0,1'b1,16'h0000,16'h0000,4'd2},
    // R5 right peeks left mailbox
    '{1'b0,1'b0,8'h00,16'h0000,1'b0, 1'b1,1'b0,8'hFF,16'h0000,1'b0, 1'b0,1'b1,16'h0000,16'hA5A5,4'd5},
    // R6 left write while busy
    '{1'b1,1'b1,8'hFE,16'h1111,1'b1, 1'b0,1'b0,8'h00,16'h0000,1'b0, 1'b0,1'b1,16'h0000,16'h0000,4'd6},
    // R6 nothing was stored
    '{1'b0,1'b0,8'h00,16'h0000,1'b0, 1'b1,1'b0,8'hFE,16'h0000,1'b0, 1'b0,1'b1,16'h0000,16'h0000,4'd6},
    // R3 left delivers to right mailbox
    '{1'b1,1'b1,8'hFE,16'h2222,1'b0, 1'b0,1'b0,8'h00,16'h0000,1'b0, 1'b0,1'b0,16'h0000,16'h0000,4'd3},
    // R7 left acknowledges while busy
    '{1'b1,1'b0,8'hFF,16'h0000,1'b1, 1'b0,1'b0,8'h00,16'h0000,1'b0, 1'b0,1'b0,16'hA5A5,16'h0000,4'd7},
    // R8 ack and new delivery together
    '{1'b1,1'b0,8'hFF,16'h0000,1'b0, 1'b1,1'b1,8'hFF,16'h3333,1'b0, 1'b0,1'b0,16'hA5A5,16'h0000,4'd8},
    // R4 left acknowledges
    '{1'b1,1'b0,8'hFF,16'h0000,1'b0, 1'b0,1'b0,8'h00,16'h0000,1'b0, 1'b1,1'b0,16'h3333,16'h0000,4'd4},
    // R10 left writes own mailbox
    '{1'b1,1'b1,8'hFF,16'h7777,1'b0, 1'b0,1'b0,8'h00,16'h0000,1'b0, 1'b1,1'b0,16'h0000,16'h0000,4'd10},
    // R10 contents unchanged
    '{1'b1,1'b0,8'hFF,16'h0000,1'b0, 1'b0,1'b0,8'h00,16'h0000,1'b0, 1'b1,1'b0,16'h3333,16'h0000,4'd10},
    // R4 right acknowledges
    '{1'b0,1'b0,8'h00,16'h0000,1'b0, 1'b1,1'b0,8'hFE,16'h0000,1'b0, 1'b1,1'b1,16'h0000,16'h2222,4'd4},
    // R9 other address and cs low writes
    '{1'b0,1'b1,8'hFE,16'h9999,1'b0, 1'b1,1'b1,8'h10,16'h8888,1'b0, 1'b1,1'b1,16'h0000,16'h0000,4'd9},
    // R9 other-address read gives zero, mailbox intact
    '{1'b1,1'b0,8'hFE,16'h0000,1'b0, 1'b1,1'b0,8'h10,16'h0000,1'b0, 1'b1,1'b1,16'h2222,16'h0000,4'd9}
  };

  task automatic chk(input int req, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    l_cs = 0; l_we = 0; l_addr = '0; l_wdata = '0; l_busy = 0;
    r_cs = 0; r_we = 0; r_addr = '0; r_wdata = '0; r_busy = 0;
  endtask

  task automatic check_reset_state(input string what);
    chk(1, {what, " l_irq_n"}, {15'd0, l_irq_n}, 16'd1);
    chk(1, {what, " r_irq_n"}, {15'd0, r_irq_n}, 16'd1);
    chk(1, {what, " l_rdata"}, l_rdata, 16'h0000);
    chk(1, {what, " r_rdata"}, r_rdata, 16'h0000);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("R1 after release");

    for (int i = 0; i < NV; i++) begin
      l_cs = VEC[i].lcs; l_we = VEC[i].lwe; l_addr = VEC[i].la;
      l_wdata = VEC[i].lw; l_busy = VEC[i].lb;
      r_cs = VEC[i].rcs; r_we = VEC[i].rwe; r_addr = VEC[i].ra;
      r_wdata = VEC[i].rw; r_busy = VEC[i].rb;
      @(negedge clk);
      chk(int'(VEC[i].req), $sformatf("vec%0d l_irq_n", i), {15'd0, l_irq_n}, {15'd0, VEC[i].elirq});
      chk(int'(VEC[i].req), $sformatf("vec%0d r_irq_n", i), {15'd0, r_irq_n}, {15'd0, VEC[i].erirq});
      chk(int'(VEC[i].req), $sformatf("vec%0d l_rdata", i), l_rdata, VEC[i].elrd);
      chk(int'(VEC[i].req), $sformatf("vec%0d r_rdata", i), r_rdata, VEC[i].errd);
    end

    // R8 directed: the simultaneous delivery left the new word stored
    idle();
    l_cs = 1; l_addr = 8'hFF;
    @(negedge clk);
    chk(8, "R8 new word after collision", l_rdata, 16'h3333);

    // R7 directed: busy right ack keeps flag, later ack releases it
    idle();
    l_cs = 1; l_we = 1; l_addr = 8'hFE; l_wdata = 16'h4444;
    @(negedge clk);
    idle();
    r_cs = 1; r_addr = 8'hFE; r_busy = 1;
    @(negedge clk);
    chk(7, "R7 right flag under busy ack", {15'd0, r_irq_n}, 16'd0);
    chk(7, "R7 right data under busy", r_rdata, 16'h4444);
    idle();
    r_cs = 1; r_addr = 8'hFE;
    @(negedge clk);
    chk(4, "R4 right flag after ack", {15'd0, r_irq_n}, 16'd1);

    // R1 directed: reset mid-operation with a pending flag
    idle();
    r_cs = 1; r_we = 1; r_addr = 8'hFF; r_wdata = 16'h5555;
    @(negedge clk);
    idle();
    chk(2, "R2 flag before reset", {15'd0, l_irq_n}, 16'd0);
    rst_n = 1'b0;
    #1;
    check_reset_state("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    l_cs = 1; l_addr = 8'hFF;
    @(negedge clk);
    chk(1, "R1 mailbox cleared by reset", l_rdata, 16'h0000);
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule